// File: doc/BRIEF.md
# Anticollision Identifier Cascade Responder

This block forms the card-side answers to the anticollision and select steps of an ISO/IEC 14443-3 Type A activation. A reader names a cascade level and either asks for the identifier frame at that level or selects it. The block answers with a five-byte frame: four payload bytes followed by a check byte. It also raises a completion pulse when the select at the last cascade level of the current identifier arrives.

Three identifier modes are supported. The first is a stored 4-byte identifier answered at one level. The second is a stored 7-byte identifier split over two levels, with a cascade tag heading the first part. The third is a random identifier: a fixed tag byte and three random bytes, taken once per field activation and held for the whole selection. The random mode is honoured only at the top security level, and while it is in use the stored identifier never appears on the output. The stored identifier bytes come in on an input, and the block has no path that can change them.

Top module: `uid_cascade_resp`

## Requirements
- R1: While reset is asserted and after it is released, resp_valid, uid_done and lvl_err are low and resp_data is zero until the first request.
- R2: In 4-byte mode (uid_len7=0 and random mode not in effect), an ac_req at casc_lvl=1 gives resp_valid one cycle later with bytes 0..3 equal to uid_bytes bytes 0..3, unchanged. Byte k of resp_data is resp_data[8k+7:8k] and byte k of uid_bytes is uid_bytes[8k+7:8k].
- R3: In 7-byte mode (uid_len7=1, random mode not in effect), level 1 answers 88h followed by identifier bytes 0, 1, 2, and level 2 (casc_lvl=2) answers identifier bytes 3, 4, 5, 6.
- R4: In random mode the level-1 frame is 08h followed by the captured random bytes, rnd_word[7:0] first, then [15:8], then [23:16]; no stored identifier byte appears. Random mode takes precedence over uid_len7.
- R5: Random mode is in effect only when rand_en=1 and sec_lvl=3; otherwise the fixed identifier chosen by uid_len7 is used.
- R6: The check byte (resp_data[39:32]) is the XOR of the four payload bytes, so all five bytes XOR to zero.
- R7: The random bytes are captured from rnd_word on the first clock with field_on high after reset or after field_on was low. They are held across repeated requests, and a request in the capture cycle already answers with the new bytes.
- R8: A request at level 2 in 4-byte or random mode, or at a level code of 0 or 3, gives no response and a one-cycle lvl_err pulse one cycle later.
- R9: A sel_req at the final level (level 1 for 4-byte and random, level 2 for 7-byte) gives a one-cycle uid_done pulse one cycle later. A select at level 1 of a 7-byte identifier gives neither uid_done nor lvl_err, and a select at an invalid level gives lvl_err.
- R10: ac_req and sel_req in the same cycle are both served: the frame and the completion pulse appear together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| field_on | input | 1 | High while the card is powered by the field; a new high period starts an activation |
| uid_len7 | input | 1 | 1 selects the 7-byte stored identifier, 0 the 4-byte one |
| rand_en | input | 1 | Configuration bit asking for the random identifier |
| sec_lvl | input | 2 | Current security level, 0 to 3 |
| uid_bytes | input | 56 | Stored identifier, byte 0 in bits 7:0 |
| rnd_word | input | 24 | Random source, three bytes |
| casc_lvl | input | 2 | Cascade level of the request, 1 or 2 |
| ac_req | input | 1 | Anticollision request strobe |
| sel_req | input | 1 | Select strobe |
| resp_valid | output | 1 | One-cycle pulse marking a new frame |
| resp_data | output | 40 | Response frame, byte 0 in bits 7:0, check byte in bits 39:32 |
| uid_done | output | 1 | One-cycle pulse: selection at the final level done |
| lvl_err | output | 1 | One-cycle pulse: request at a level with no answer |

## Verification
Two pairs of functions can land in one cycle. The first pair is the capture of the random bytes at the start of an activation and a random-mode request. The bench raises field_on on the same edge as ac_req, with a fresh value on rnd_word. It expects the frame to carry that fresh value, and expects later requests to keep it even after rnd_word moves. The second pair is a frame request and a select strobed together. The bench expects both the frame and the completion pulse on the following cycle, at level 1 of a 4-byte identifier and at level 2 of a 7-byte one.

// File: rtl/uidc_pkg.sv
`timescale 1ns/1ps
package uidc_pkg;
  localparam int BYTE_W       = 8;
  localparam int FRAME_BYTES  = 5;
  localparam int PAY_BYTES    = FRAME_BYTES - 1;
  localparam logic [BYTE_W-1:0] TAG_CASCADE = 8'h88;
  localparam logic [BYTE_W-1:0] TAG_RANDOM  = 8'h08;
  localparam logic [1:0] LVL_ONE   = 2'd1;
  localparam logic [1:0] LVL_TWO   = 2'd2;
  localparam logic [1:0] SEC_TOP   = 2'd3;

  typedef enum logic [1:0] {
    IDM_SHORT  = 2'd0,
    IDM_DOUBLE = 2'd1,
    IDM_RANDOM = 2'd2
  } id_mode_e;
endpackage

// File: rtl/uidc_rst_sync.sv
`timescale 1ns/1ps
module uidc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/uidc_mode_dec.sv
`timescale 1ns/1ps
module uidc_mode_dec
  import uidc_pkg::*;
(
  input  logic           uid_len7,
  input  logic           rand_en,
  input  logic [1:0]     sec_lvl,
  input  logic [1:0]     casc_lvl,
  output id_mode_e       mode,
  output logic           lvl_ok,
  output logic           lvl_last
);
  always_comb begin
    if (rand_en && (sec_lvl == SEC_TOP)) mode = IDM_RANDOM;
    else if (uid_len7)                   mode = IDM_DOUBLE;
    else                                 mode = IDM_SHORT;

    lvl_ok   = (casc_lvl == LVL_ONE) ||
               ((casc_lvl == LVL_TWO) && (mode == IDM_DOUBLE));
    lvl_last = (mode != IDM_DOUBLE) || (casc_lvl == LVL_TWO);
  end
endmodule

// File: rtl/uidc_rnd_latch.sv
`timescale 1ns/1ps
module uidc_rnd_latch #(
  parameter int RND_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_on,
  input  logic [RND_W-1:0] rnd_word,
  output logic [RND_W-1:0] rnd_eff
);
  logic             armed_q, armed_d;
  logic [RND_W-1:0] rnd_q, rnd_d;
  logic             cap;

  always_comb begin
    cap     = field_on & armed_q;
    armed_d = ~field_on;
    rnd_d   = cap ? rnd_word : rnd_q;
    rnd_eff = rnd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      rnd_q   <= '0;
    end else begin
      armed_q <= armed_d;
      if (cap) rnd_q <= rnd_d;
    end
  end

  // R7: once captured, the random bytes hold while the field stays up
  assert_rnd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (field_on && !armed_q) |=> $stable(rnd_q));
endmodule

// File: rtl/uidc_frame_build.sv
`timescale 1ns/1ps
module uidc_frame_build
  import uidc_pkg::*;
#(
  parameter int UID_BYTES = 7,
  parameter int RND_BYTES = 3
) (
  input  id_mode_e                       mode,
  input  logic                           is_l2,
  input  logic [UID_BYTES*BYTE_W-1:0]    uid,
  input  logic [RND_BYTES*BYTE_W-1:0]    rnd,
  output logic [FRAME_BYTES*BYTE_W-1:0]  frame
);
  localparam int UID_W = UID_BYTES * BYTE_W;
  localparam int PAY_W = PAY_BYTES * BYTE_W;

  logic [PAY_W-1:0]  pay;
  logic [BYTE_W-1:0] acc [0:PAY_BYTES];

  always_comb begin
    case (mode)
      IDM_RANDOM: pay = {rnd, TAG_RANDOM};
      IDM_DOUBLE: pay = is_l2 ? uid[UID_W-1 -: PAY_W]
                              : {uid[PAY_W-BYTE_W-1:0], TAG_CASCADE};
      default:    pay = uid[PAY_W-1:0];
    endcase
  end

  assign acc[0] = '0;
  for (genvar i = 0; i < PAY_BYTES; i++) begin : g_bcc
    assign acc[i+1] = acc[i] ^ pay[i*BYTE_W +: BYTE_W];
  end

  assign frame = {acc[PAY_BYTES], pay};
endmodule

// File: rtl/uid_cascade_resp.sv
`timescale 1ns/1ps
module uid_cascade_resp
  import uidc_pkg::*;
#(
  parameter int UID_BYTES = 7,
  parameter int RND_BYTES = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          field_on,
  input  logic                          uid_len7,
  input  logic                          rand_en,
  input  logic [1:0]                    sec_lvl,
  input  logic [UID_BYTES*8-1:0]        uid_bytes,
  input  logic [RND_BYTES*8-1:0]        rnd_word,
  input  logic [1:0]                    casc_lvl,
  input  logic                          ac_req,
  input  logic                          sel_req,
  output logic                          resp_valid,
  output logic [FRAME_BYTES*8-1:0]      resp_data,
  output logic                          uid_done,
  output logic                          lvl_err
);
  localparam int UID_W   = UID_BYTES * BYTE_W;
  localparam int RND_W   = RND_BYTES * BYTE_W;
  localparam int FRAME_W = FRAME_BYTES * BYTE_W;
  localparam int PAY_W   = PAY_BYTES * BYTE_W;

  logic               rst_s_n;
  id_mode_e           mode;
  logic               lvl_ok, lvl_last;
  logic [RND_W-1:0]   rnd_eff;
  logic [FRAME_W-1:0] frame;

  logic               resp_v_q, resp_v_d;
  logic [FRAME_W-1:0] data_q, data_d;
  logic               done_q, done_d;
  logic               err_q, err_d;

  uidc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  uidc_mode_dec u_dec (
    .uid_len7(uid_len7), .rand_en(rand_en), .sec_lvl(sec_lvl),
    .casc_lvl(casc_lvl), .mode(mode), .lvl_ok(lvl_ok), .lvl_last(lvl_last)
  );

  uidc_rnd_latch #(.RND_W(RND_W)) u_rnd (
    .clk(clk), .rst_n(rst_s_n), .field_on(field_on),
    .rnd_word(rnd_word), .rnd_eff(rnd_eff)
  );

  uidc_frame_build #(.UID_BYTES(UID_BYTES), .RND_BYTES(RND_BYTES)) u_frm (
    .mode(mode), .is_l2(casc_lvl == LVL_TWO), .uid(uid_bytes),
    .rnd(rnd_eff), .frame(frame)
  );

  always_comb begin
    resp_v_d = ac_req & lvl_ok;
    done_d   = sel_req & lvl_ok & lvl_last;
    err_d    = (ac_req | sel_req) & ~lvl_ok;
    data_d   = resp_v_d ? frame : data_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      resp_v_q <= 1'b0;
      data_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      resp_v_q <= resp_v_d;
      if (resp_v_d) data_q <= data_d;
      done_q   <= done_d;
      err_q    <= err_d;
    end
  end

  assign resp_valid = resp_v_q;
  assign resp_data  = data_q;
  assign uid_done   = done_q;
  assign lvl_err    = err_q;

  // R6: the five bytes of every frame XOR to zero
  assert_frame_xor_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    resp_v_q |-> ((data_q[7:0] ^ data_q[15:8] ^ data_q[23:16] ^
                   data_q[31:24] ^ data_q[39:32]) == 8'h00));

  // R2: a short identifier is copied unchanged
  assert_short_copy_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ac_req && mode == IDM_SHORT && casc_lvl == LVL_ONE)
      |=> (resp_v_q && data_q[PAY_W-1:0] == $past(uid_bytes[PAY_W-1:0])));

  // R3: first part of a 7-byte identifier starts with the cascade tag
  assert_dbl_tag_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ac_req && mode == IDM_DOUBLE && casc_lvl == LVL_ONE)
      |=> (data_q[7:0] == TAG_CASCADE));

  // R3: second part carries the upper identifier bytes
  assert_dbl_tail_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ac_req && mode == IDM_DOUBLE && casc_lvl == LVL_TWO)
      |=> (data_q[PAY_W-1:0] == $past(uid_bytes[UID_W-1 -: PAY_W])));

  // R4: random frames start with the random tag
  assert_rand_tag_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ac_req && mode == IDM_RANDOM && casc_lvl == LVL_ONE)
      |=> (data_q[7:0] == TAG_RANDOM));

  // R5: random mode only at the top security level
  assert_rand_gate_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode == IDM_RANDOM) |-> (sec_lvl == SEC_TOP && rand_en));

  // R8: an unanswerable level yields an error and no frame
  assert_l2_err_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ac_req && casc_lvl == LVL_TWO && mode != IDM_DOUBLE)
      |=> (err_q && !resp_v_q));

  // R9: completion and error never coincide
  assert_done_err_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(done_q && err_q));
endmodule

// File: tb/uid_cascade_resp_tb.sv
`timescale 1ns/1ps
module uid_cascade_resp_tb;
  localparam logic [2:0] K_NONE = 3'd0, K_S1 = 3'd1, K_D1 = 3'd2,
                         K_D2 = 3'd3, K_R = 3'd4;
  localparam logic [55:0] UID = 56'h706F5E4D3C2B1A;
  localparam logic [23:0] R_A = 24'hC3B2A1;
  localparam logic [23:0] R_B = 24'h1E2D3C;
  localparam logic [23:0] R_C = 24'h9F8E7D;

  typedef struct packed {
    logic       len7;
    logic       rcfg;
    logic [1:0] sec;
    logic [1:0] lvl;
    logic       req;
    logic       sel;
    logic       ev;
    logic       ed;
    logic       ee;
    logic [2:0] kind;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,2'd0,2'd1,1'b1,1'b0,1'b1,1'b0,1'b0,K_S1,4'd2},   // R2
    '{1'b0,1'b0,2'd0,2'd1,1'b0,1'b1,1'b0,1'b1,1'b0,K_NONE,4'd9}, // R9
    '{1'b0,1'b0,2'd0,2'd1,1'b1,1'b1,1'b1,1'b1,1'b0,K_S1,4'd10},  // R10
    '{1'b1,1'b0,2'd0,2'd1,1'b1,1'b0,1'b1,1'b0,1'b0,K_D1,4'd3},   // R3
    '{1'b1,1'b0,2'd0,2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,K_NONE,4'd9}, // R9
    '{1'b1,1'b0,2'd0,2'd2,1'b1,1'b0,1'b1,1'b0,1'b0,K_D2,4'd3},   // R3
    '{1'b1,1'b0,2'd0,2'd2,1'b0,1'b1,1'b0,1'b1,1'b0,K_NONE,4'd9}, // R9
    '{1'b0,1'b1,2'd3,2'd1,1'b1,1'b0,1'b1,1'b0,1'b0,K_R,4'd4},    // R4
    '{1'b1,1'b1,2'd3,2'd1,1'b1,1'b0,1'b1,1'b0,1'b0,K_R,4'd4},    // R4
    '{1'b1,1'b1,2'd2,2'd1,1'b1,1'b0,1'b1,1'b0,1'b0,K_D1,4'd5},   // R5
    '{1'b0,1'b1,2'd1,2'd1,1'b1,1'b0,1'b1,1'b0,1'b0,K_S1,4'd5},   // R5
    '{1'b0,1'b0,2'd0,2'd2,1'b1,1'b0,1'b0,1'b0,1'b1,K_NONE,4'd8}, // R8
    '{1'b0,1'b1,2'd3,2'd2,1'b1,1'b0,1'b0,1'b0,1'b1,K_NONE,4'd8}, // R8
    '{1'b1,1'b0,2'd0,2'd0,1'b1,1'b0,1'b0,1'b0,1'b1,K_NONE,4'd8}, // R8
    '{1'b0,1'b1,2'd3,2'd2,1'b0,1'b1,1'b0,1'b0,1'b1,K_NONE,4'd9}, // R9
    '{1'b0,1'b1,2'd3,2'd1,1'b0,1'b1,1'b0,1'b1,1'b0,K_NONE,4'd9}, // R9
    '{1'b1,1'b0,2'd0,2'd2,1'b1,1'b1,1'b1,1'b1,1'b0,K_D2,4'd10}   // R10
  };

  logic        clk = 1'b0;
  logic        rst_n, field_on, uid_len7, rand_en, ac_req, sel_req;
  logic [1:0]  sec_lvl, casc_lvl;
  logic [55:0] uid_bytes;
  logic [23:0] rnd_word;
  logic        resp_valid, uid_done, lvl_err;
  logic [39:0] resp_data;
  int          n_cmp = 0, n_bad = 0;
  logic        finished = 1'b0;

  always #2 clk = ~clk;

  uid_cascade_resp u_dut (
    .clk(clk), .rst_n(rst_n), .field_on(field_on), .uid_len7(uid_len7),
    .rand_en(rand_en), .sec_lvl(sec_lvl), .uid_bytes(uid_bytes),
    .rnd_word(rnd_word), .casc_lvl(casc_lvl), .ac_req(ac_req),
    .sel_req(sel_req), .resp_valid(resp_valid), .resp_data(resp_data),
    .uid_done(uid_done), .lvl_err(lvl_err)
  );

  function automatic logic [7:0] ub(input int k);
    return UID[k*8 +: 8];
  endfunction

  function automatic logic [39:0] mk(input logic [7:0] b0, b1, b2, b3);
    return {b0 ^ b1 ^ b2 ^ b3, b3, b2, b1, b0};
  endfunction

  function automatic logic [39:0] exp_frame(input logic [2:0] kind,
                                            input logic [23:0] r);
    case (kind)
      K_S1:    return mk(ub(0), ub(1), ub(2), ub(3));
      K_D1:    return mk(8'h88, ub(0), ub(1), ub(2));
      K_D2:    return mk(ub(3), ub(4), ub(5), ub(6));
      K_R:     return mk(8'h08, r[7:0], r[15:8], r[23:16]);
      default: return 40'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic l7, rc, input logic [1:0] sec, lvl,
                       input logic rq, sl);
    @(negedge clk);
    uid_len7 = l7; rand_en = rc; sec_lvl = sec; casc_lvl = lvl;
    ac_req = rq; sel_req = sl;
    @(negedge clk);
    ac_req = 1'b0; sel_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; field_on = 1'b1; uid_len7 = 1'b0; rand_en = 1'b0;
    sec_lvl = 2'd0; casc_lvl = 2'd1; ac_req = 1'b0; sel_req = 1'b0;
    uid_bytes = UID; rnd_word = R_A;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check("R1 in reset", {60'h0, resp_valid, uid_done, lvl_err, 1'b0}, 64'h0);
    check("R1 data in reset", {24'h0, resp_data}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", {60'h0, resp_valid, uid_done, lvl_err, 1'b0}, 64'h0);
    rnd_word = 24'h5A5A5A;   // capture of R_A must already be done (R7)

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].len7, VECS[i].rcfg, VECS[i].sec, VECS[i].lvl,
            VECS[i].req, VECS[i].sel);
      check($sformatf("R%0d row %0d flags", VECS[i].rq, i),
            {61'h0, resp_valid, uid_done, lvl_err},
            {61'h0, VECS[i].ev, VECS[i].ed, VECS[i].ee});
      if (VECS[i].ev)
        check($sformatf("R%0d row %0d frame", VECS[i].rq, i),
              {24'h0, resp_data}, {24'h0, exp_frame(VECS[i].kind, R_A)});
    end

    // R6: check byte closes the XOR of the frame
    apply(1'b1, 1'b0, 2'd0, 2'd2, 1'b1, 1'b0);
    check("R6 xor", {56'h0, resp_data[7:0] ^ resp_data[15:8] ^ resp_data[23:16]
                            ^ resp_data[31:24] ^ resp_data[39:32]}, 64'h0);

    // R7: new activation, capture and request on the same edge
    @(negedge clk); field_on = 1'b0;
    repeat (2) @(negedge clk);
    rnd_word = R_B; field_on = 1'b1;
    uid_len7 = 1'b0; rand_en = 1'b1; sec_lvl = 2'd3; casc_lvl = 2'd1;
    ac_req = 1'b1;
    @(negedge clk); ac_req = 1'b0;
    check("R7 same-cycle capture", {24'h0, resp_data}, {24'h0, exp_frame(K_R, R_B)});
    rnd_word = R_C;
    apply(1'b0, 1'b1, 2'd3, 2'd1, 1'b1, 1'b0);
    check("R7 held 1", {24'h0, resp_data}, {24'h0, exp_frame(K_R, R_B)});
    apply(1'b0, 1'b1, 2'd3, 2'd1, 1'b1, 1'b0);
    check("R7 held 2", {24'h0, resp_data}, {24'h0, exp_frame(K_R, R_B)});
    @(negedge clk); field_on = 1'b0;
    @(negedge clk); field_on = 1'b1;
    @(negedge clk); rnd_word = 24'h000000;
    apply(1'b0, 1'b1, 2'd3, 2'd1, 1'b1, 1'b0);
    check("R7 recapture", {24'h0, resp_data}, {24'h0, exp_frame(K_R, R_C)});

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule